// File: doc/BRIEF.md
# Bytewide Nonvolatile Memory Bus Sequencer

This block sits between a synchronous host and a bytewide parallel nonvolatile memory. That memory starts an internal cycle on every falling edge of its chip enable, and it must see chip enable held high for a precharge interval before the next cycle can begin. The host sends one word at a time on a valid/ready request channel. Each request carries an address, a write flag and write data. Read results come back on a single-cycle response strobe.

The block turns each accepted request into one complete pin sequence with three phases. The first is an address setup phase, with chip enable high and the address already driven. The second is a chip-enable-low access phase. The last is a precharge phase, with every strobe inactive.

Writes are issued as chip-enable-controlled cycles. Write enable is already low when chip enable falls, so the memory never drives the bus, and the write is finished when chip enable rises. No completion polling is needed. Reads assert output enable only while chip enable is low. The block releases its own data drivers whenever output enable is low.

The three phase lengths come from clock-count inputs. They are sampled when a request is accepted.

Top module: `fram_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, mem_ce_n, mem_we_n and mem_oe_n are high, mem_dq_oe is low, req_ready is high and rsp_valid is low.
- R2: Each accepted request gives exactly one low pulse on mem_ce_n. It is preceded by S cycles with mem_ce_n high, and it lasts exactly A cycles. S = max(cfg_setup,1) and A = max(cfg_access,1).
- R3: mem_addr equals the accepted request's address during setup. It does not change while mem_ce_n is low.
- R4: After mem_ce_n rises, it stays high for P = max(cfg_precharge,1) cycles. req_ready is low for exactly S+A+P cycles after the acceptance edge, and then it is high again so that a new request can be accepted at once.
- R5: On a write, mem_we_n is already low when mem_ce_n falls, and it rises on the same clock edge as mem_ce_n. mem_oe_n stays high. mem_dq_oe is high with mem_dq_o equal to the write data through setup and access. The memory holds the data for later reads.
- R6: On a read, mem_oe_n is low exactly while mem_ce_n is low, and mem_dq_oe stays low. mem_dq_i is sampled at the edge that ends the access. It is returned on rsp_rdata with rsp_valid high for one cycle, which is the first precharge cycle.
- R7: A write produces no rsp_valid pulse.
- R8: A count input of 0 is treated as 1 for each of the three phases.
- R9: The timing counts are sampled at acceptance. Changing them while a request is in progress has no effect on that request.
- R10: mem_dq_oe is never high while mem_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | CNT_W | Address setup length in clocks before chip enable falls |
| cfg_access | input | CNT_W | Access length in clocks with chip enable low |
| cfg_precharge | input | CNT_W | Precharge length in clocks with chip enable high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_i | input | DATA_W | Data received from the memory |

## Verification
The hardest case to reach is a change of the timing counts while a request is already in flight. Any bench that sets the counts before issuing a request never exercises it. To get there, the bench lets the request be accepted, then rewrites the access count during setup. It checks that the chip-enable pulse still has the length sampled at acceptance. The bench also runs a zero-count request, in which every phase collapses to one clock. It checks, through a behavioural memory, that a read issued right after a write returns the data that the write committed on the chip-enable rising edge.

// File: rtl/fram_ctrl_pkg.sv
package fram_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_PRECH  = 2'd3
  } phase_t;

  // strobe decode shared by the pin driver
  function automatic logic phase_drives_addr(input phase_t ph);
    return (ph == PH_SETUP) || (ph == PH_ACCESS);
  endfunction
endpackage

// File: rtl/fram_seq.sv
module fram_seq
  import fram_ctrl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_access,
  input  logic [CNT_W-1:0] cfg_precharge,
  output logic             accept,
  output logic             idle,
  output logic             acc_done,
  output phase_t           ph_next
);
  // zero is treated as one clock: countdown starts at span-1
  function automatic logic [CNT_W-1:0] last_tick(input logic [CNT_W-1:0] raw);
    return (raw == '0) ? '0 : raw - 1'b1;
  endfunction

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] acc_lim_q, pre_lim_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign idle     = (ph_q == PH_IDLE);
  assign accept   = idle && req_valid;
  assign acc_done = (ph_q == PH_ACCESS) && cnt_zero;

  always_comb begin
    ph_next = ph_q;
    cnt_d   = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          ph_next = PH_SETUP;
          cnt_d   = last_tick(cfg_setup);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          ph_next = PH_ACCESS;
          cnt_d   = last_tick(acc_lim_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACCESS: begin
        if (cnt_zero) begin
          ph_next = PH_PRECH;
          cnt_d   = last_tick(pre_lim_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PRECH: begin
        if (cnt_zero) ph_next = PH_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: ph_next = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      acc_lim_q <= '0;
      pre_lim_q <= '0;
    end else begin
      ph_q  <= ph_next;
      cnt_q <= cnt_d;
      if (accept) begin
        acc_lim_q <= cfg_access;
        pre_lim_q <= cfg_precharge;
      end
    end
  end
endmodule

// File: rtl/fram_pin_drv.sv
module fram_pin_drv
  import fram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            ph_next,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cyc_write,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);
  logic wr_next;
  logic active_next;

  assign wr_next     = accept ? req_write : cyc_write;
  assign active_next = phase_drives_addr(ph_next);

  // pins are registered from the next phase so they line up with it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_write <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      cyc_write <= wr_next;
      mem_ce_n  <= !(ph_next == PH_ACCESS);
      mem_we_n  <= !(wr_next && active_next);
      mem_oe_n  <= !(!wr_next && (ph_next == PH_ACCESS));
      mem_dq_oe <= wr_next && active_next;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/fram_rd_capture.sv
module fram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_done,
  input  logic              cyc_write,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic take;
  assign take = acc_done && !cyc_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_rdata <= mem_dq_i;
    end
  end
endmodule

// File: rtl/fram_bus_ctrl.sv
module fram_bus_ctrl
  import fram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_access,
  input  logic [CNT_W-1:0]  cfg_precharge,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // named internal events, visible to the bound checker
  logic   accept;
  logic   idle;
  logic   acc_done;
  logic   cyc_write;
  phase_t ph_next;

  assign req_ready = idle;

  fram_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .cfg_setup    (cfg_setup),
    .cfg_access   (cfg_access),
    .cfg_precharge(cfg_precharge),
    .accept       (accept),
    .idle         (idle),
    .acc_done     (acc_done),
    .ph_next      (ph_next)
  );

  fram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph_next   (ph_next),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cyc_write (cyc_write),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
  );

  fram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_done  (acc_done),
    .cyc_write (cyc_write),
    .mem_dq_i  (mem_dq_i),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/fram_bus_ctrl_chk.sv
module fram_bus_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              acc_done
);
  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_ce_rises_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> mem_ce_n);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_we_ends_with_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !mem_ce_n) |=> (mem_we_n == mem_ce_n));

  assert_no_oe_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  assert_bus_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
endmodule

bind fram_bus_ctrl fram_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fram_bus_ctrl_tb.sv
module fram_bus_ctrl_tb;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int CW = 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [3:0]    s;
    logic [3:0]    a;
    logic [3:0]    p;
  } vec_t;

  // write: data = value stored; read: data = value expected back
  localparam vec_t VECS [9] = '{
    '{1'b1, 15'h0012, 8'hA5, 4'd1, 4'd2, 4'd1},
    '{1'b0, 15'h0012, 8'hA5, 4'd1, 4'd2, 4'd1},
    '{1'b1, 15'h7F34, 8'h3C, 4'd2, 4'd3, 4'd2},
    '{1'b0, 15'h7F34, 8'h3C, 4'd0, 4'd0, 4'd0},
    '{1'b1, 15'h0056, 8'hFF, 4'd0, 4'd1, 4'd3},
    '{1'b0, 15'h0056, 8'hFF, 4'd3, 4'd4, 4'd1},
    '{1'b0, 15'h0012, 8'hA5, 4'd1, 4'd1, 4'd0},
    '{1'b1, 15'h0012, 8'h00, 4'd1, 4'd5, 4'd2},
    '{1'b0, 15'h0012, 8'h00, 4'd2, 4'd2, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_setup = '0, cfg_access = '0, cfg_precharge = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  fram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_access(cfg_access), .cfg_precharge(cfg_precharge),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // behavioural memory: cycle starts on chip-enable fall, write lands on rise
  logic [DW-1:0] mem [256];
  logic [7:0]    lat_addr = '0;
  logic          lat_wr = 1'b0;
  always @(negedge mem_ce_n) begin
    lat_addr = mem_addr[7:0];
    lat_wr   = !mem_we_n;
  end
  always @(posedge mem_ce_n) if (lat_wr) mem[lat_addr] = mem_dq_o;
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? mem[lat_addr] : 8'hEE;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int late_acc = -1;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int span(input int raw);
    return (raw < 1) ? 1 : raw;
  endfunction

  task automatic run_op(input vec_t v, output int ce_low, output int busy,
                        output int setup_hi, output int rsp_n, output int rd,
                        output int bad_addr, output int bad_wr,
                        output int bad_rd, output int bad_bus);
    logic [AW-1:0] prev_addr;
    bit prev_ce_low;
    ce_low = 0; busy = 0; setup_hi = 0; rsp_n = 0; rd = -1;
    bad_addr = 0; bad_wr = 0; bad_rd = 0; bad_bus = 0;
    prev_ce_low = 1'b0; prev_addr = '0;
    @(negedge clk);
    cfg_setup = CW'(v.s); cfg_access = CW'(v.a); cfg_precharge = CW'(v.p);
    req_write = v.wr; req_addr = v.addr; req_wdata = v.data; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~v.addr; req_wdata = ~v.data;
    if (late_acc >= 0) cfg_access = CW'(late_acc);
    while (!req_ready) begin
      busy++;
      if (mem_addr != v.addr && (mem_ce_n == 1'b0 || ce_low == 0)) bad_addr++;
      if (!mem_ce_n) begin
        if (prev_ce_low && mem_addr != prev_addr) bad_addr++;
        if (ce_low == 0 && v.wr && mem_we_n) bad_wr++;
        ce_low++;
      end else if (ce_low == 0) setup_hi++;
      if (v.wr) begin
        if (!mem_oe_n) bad_wr++;
        if ((ce_low == 0 || !mem_ce_n) && !(mem_dq_oe && mem_dq_o == v.data)) bad_wr++;
        if (ce_low > 0 && mem_ce_n && !mem_we_n) bad_wr++;
      end else begin
        if (mem_oe_n != mem_ce_n || mem_dq_oe) bad_rd++;
      end
      if (mem_dq_oe && !mem_oe_n) bad_bus++;
      if (rsp_valid) begin rsp_n++; rd = int'(rsp_rdata); end
      prev_ce_low = !mem_ce_n; prev_addr = mem_addr;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  end

  initial begin
    int ce_low, busy, setup_hi, rsp_n, rd, ba, bw, br, bb;
    repeat (3) @(negedge clk);
    // R1: reset state while held and just after release
    chk("R1 ce_n", mem_ce_n, 1); chk("R1 we_n", mem_we_n, 1);
    chk("R1 oe_n", mem_oe_n, 1); chk("R1 dq_oe", mem_dq_oe, 0);
    chk("R1 ready", req_ready, 1); chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", req_ready, 1);
    chk("R1 ce_n after release", mem_ce_n, 1);

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      run_op(v, ce_low, busy, setup_hi, rsp_n, rd, ba, bw, br, bb);
      chk("R2 setup length", setup_hi, span(v.s));
      chk("R2 R8 access length", ce_low, span(v.a));
      chk("R4 R8 busy length", busy, span(v.s) + span(v.a) + span(v.p));
      chk("R3 address", ba, 0);
      chk("R10 bus release", bb, 0);
      if (v.wr) begin
        chk("R5 write strobes", bw, 0);
        chk("R7 no write response", rsp_n, 0);
      end else begin
        chk("R6 read strobes", br, 0);
        chk("R6 response count", rsp_n, 1);
        chk("R6 read data", rd, int'(v.data));
      end
    end

    // R9: access count rewritten after acceptance must not matter
    late_acc = 7;
    run_op('{1'b0, 15'h0012, 8'h00, 4'd1, 4'd2, 4'd1}, ce_low, busy, setup_hi,
           rsp_n, rd, ba, bw, br, bb);
    late_acc = -1;
    chk("R9 access length kept", ce_low, 2);
    chk("R9 busy length kept", busy, 4);
    chk("R9 read data", rd, 0);

    // R4: next request is accepted right after precharge
    run_op('{1'b1, 15'h0077, 8'h5A, 4'd1, 4'd1, 4'd1}, ce_low, busy, setup_hi,
           rsp_n, rd, ba, bw, br, bb);
    chk("R4 ready at end of precharge", req_ready, 1);
    run_op('{1'b0, 15'h0077, 8'h5A, 4'd1, 4'd1, 4'd1}, ce_low, busy, setup_hi,
           rsp_n, rd, ba, bw, br, bb);
    chk("R5 write then read data", rd, 8'h5A);
    chk("R1 idle strobes after ops", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule